// File: doc/BRIEF.md
# Paged Program Counter Load Unit

This block holds the 15-bit program counter of a small 8-bit microcontroller core and chooses its next value every instruction cycle. The upper seven address bits are normally hidden. They are staged in a separate 7-bit page latch, which software writes ahead of a jump or a write to the low PC byte. The core's decoder raises one of five load requests, or none at all. The unit then forms the next PC from a mix of page-latch bits, opcode operand bits, the working register, the ALU result, or a relative offset added to the full counter.

Each clock edge is one instruction cycle. The low PC byte is brought out separately so that it can be read back as a register. The call/return stack, instruction decode and program memory lie outside the block.

Top module: `pc_load_unit`

## Requirements
- R1: While `rst_n` is low, the program counter and the page latch are both zero.
- R2: When no bit of `ld_req` is set, the PC advances by 1 on each clock edge, and 0x7FFF wraps to 0x0000.
- R3: When `ld_req[0]` (low-byte write) wins, the next PC is {page latch, `alu_res`}.
- R4: When `ld_req[1]` (absolute jump/call) wins, the next PC is {page latch[6:3], `op_arg`[10:0]}.
- R5: When `ld_req[2]` (computed call) wins, the next PC is {page latch, `wreg`}.
- R6: When `ld_req[3]` (unsigned register branch) wins, the next PC is PC + 1 + `wreg`, with `wreg` zero-extended and the sum taken modulo 2^15.
- R7: When `ld_req[4]` (signed immediate branch) wins, the next PC is PC + 1 + `br_arg`, with the 9-bit `br_arg` sign-extended and the sum taken modulo 2^15.
- R8: When several `ld_req` bits are set, the lowest-numbered set bit selects the load and the other bits are ignored.
- R9: When `pg_we` is high, the page latch takes `pg_wdata` at the clock edge. A load made on the same edge uses the old latch value. PC loads never change the latch.
- R10: `pc_lo` always equals PC[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 5 | Load requests; bit 0 low-byte write, 1 absolute, 2 computed call, 3 unsigned branch, 4 signed branch |
| op_arg | input | 11 | Absolute target operand from the opcode |
| br_arg | input | 9 | Signed branch offset from the opcode |
| wreg | input | 8 | Working register |
| alu_res | input | 8 | ALU result written to the low PC byte |
| pg_we | input | 1 | Page latch write enable |
| pg_wdata | input | 7 | Page latch write data |
| pc | output | 15 | Current program counter |
| pc_lo | output | 8 | Low PC byte for readback |

## Verification
The assertions assume that every input is a known value at each sampled edge. They also assume that the page latch value a load uses is the one held before that edge. The checker therefore watches the latch itself and compares against its previous value. The bench drives inputs only at falling edges and never leaves them undriven. It sweeps every `ld_req` combination, every `wreg` value and every `br_arg` value, along with random page writes issued in the same cycle as loads.

// File: rtl/pc_load_unit.sv
module pc_load_unit #(
  parameter int PC_W  = 15,
  parameter int LO_W  = 8,
  parameter int JMP_W = 11,
  parameter int BR_W  = 9,
  parameter int NREQ  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   ld_req,
  input  logic [JMP_W-1:0]  op_arg,
  input  logic [BR_W-1:0]   br_arg,
  input  logic [LO_W-1:0]   wreg,
  input  logic [LO_W-1:0]   alu_res,
  input  logic              pg_we,
  input  logic [PC_W-LO_W-1:0] pg_wdata,
  output logic [PC_W-1:0]   pc,
  output logic [LO_W-1:0]   pc_lo
);
  localparam int HI_W = PC_W - LO_W;
  localparam int JHI  = PC_W - JMP_W;
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [HI_W-1:0] pg_q;
  logic [PC_W-1:0] pc_nxt;

  wire [PC_W-1:0] inc     = pc + ONE;
  wire [PC_W-1:0] w_ext   = {{HI_W{1'b0}}, wreg};
  wire [PC_W-1:0] b_ext   = {{(PC_W-BR_W){br_arg[BR_W-1]}}, br_arg};
  wire [PC_W-1:0] t_low   = {pg_q, alu_res};
  wire [PC_W-1:0] t_abs   = {pg_q[HI_W-1 -: JHI], op_arg};
  wire [PC_W-1:0] t_call  = {pg_q, wreg};
  wire [PC_W-1:0] t_brw   = inc + w_ext;
  wire [PC_W-1:0] t_bra   = inc + b_ext;

  always_comb begin
    if      (ld_req[0]) pc_nxt = t_low;
    else if (ld_req[1]) pc_nxt = t_abs;
    else if (ld_req[2]) pc_nxt = t_call;
    else if (ld_req[3]) pc_nxt = t_brw;
    else if (ld_req[4]) pc_nxt = t_bra;
    else                pc_nxt = inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      pg_q <= '0;
    end else begin
      pc <= pc_nxt;
      if (pg_we) pg_q <= pg_wdata;
    end
  end

  assign pc_lo = pc[LO_W-1:0];
endmodule

// File: rtl/pc_load_unit_chk.sv
module pc_load_unit_chk #(
  parameter int PC_W  = 15,
  parameter int LO_W  = 8,
  parameter int JMP_W = 11,
  parameter int BR_W  = 9,
  parameter int NREQ  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NREQ-1:0]      ld_req,
  input logic [JMP_W-1:0]     op_arg,
  input logic [BR_W-1:0]      br_arg,
  input logic [LO_W-1:0]      wreg,
  input logic [LO_W-1:0]      alu_res,
  input logic                 pg_we,
  input logic [PC_W-LO_W-1:0] pg,
  input logic [PC_W-1:0]      pc
);
  localparam int HI_W = PC_W - LO_W;
  localparam int JHI  = PC_W - JMP_W;

  p_seq_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req == '0) |=> pc == PC_W'($past(pc) + PC_W'(1)));

  p_low_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req[0] |=> pc == {$past(pg), $past(alu_res)});

  p_absolute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req[1:0] == 2'b10) |=> pc == {$past(pg[HI_W-1 -: JHI]), $past(op_arg)});

  p_comp_call_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req[2:0] == 3'b100) |=> pc == {$past(pg), $past(wreg)});

  p_ubranch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req[3:0] == 4'b1000) |=>
      pc == PC_W'($past(pc) + PC_W'(1) + PC_W'($past(wreg))));

  p_sbranch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req == 5'b10000) |=>
      pc == PC_W'($past(pc) + PC_W'(1) + PC_W'($signed($past(br_arg)))));

  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_we |=> $stable(pg));
endmodule

bind pc_load_unit pc_load_unit_chk #(
  .PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W), .BR_W(BR_W), .NREQ(NREQ)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .op_arg(op_arg),
  .br_arg(br_arg), .wreg(wreg), .alu_res(alu_res), .pg_we(pg_we),
  .pg(pg_q), .pc(pc)
);

// File: tb/pc_load_unit_tb.sv
module pc_load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ld_req = '0;
  logic [10:0] op_arg = '0;
  logic [8:0]  br_arg = '0;
  logic [7:0]  wreg = '0;
  logic [7:0]  alu_res = '0;
  logic        pg_we = 1'b0;
  logic [6:0]  pg_wdata = '0;
  logic [14:0] pc;
  logic [7:0]  pc_lo;

  int checks = 0;
  int fails = 0;
  logic [14:0] e_pc = '0;
  logic [6:0]  e_pg = '0;

  always #10 clk = ~clk;

  pc_load_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .op_arg(op_arg),
    .br_arg(br_arg), .wreg(wreg), .alu_res(alu_res), .pg_we(pg_we),
    .pg_wdata(pg_wdata), .pc(pc), .pc_lo(pc_lo)
  );

  task automatic check(string tag, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [4:0] r);
    if (r[0]) return "R3";
    if (r[1]) return "R4";
    if (r[2]) return "R5";
    if (r[3]) return "R6";
    if (r[4]) return "R7";
    return "R2";
  endfunction

  task automatic step(logic [4:0] r, logic [10:0] oa, logic [8:0] ba,
                      logic [7:0] w, logic [7:0] a, logic we, logic [6:0] wd);
    string t;
    ld_req = r; op_arg = oa; br_arg = ba; wreg = w; alu_res = a;
    pg_we = we; pg_wdata = wd;
    if      (r[0]) e_pc = {e_pg, a};
    else if (r[1]) e_pc = {e_pg[6:3], oa};
    else if (r[2]) e_pc = {e_pg, w};
    else if (r[3]) e_pc = e_pc + 15'd1 + {7'd0, w};
    else if (r[4]) e_pc = e_pc + 15'd1 + {{6{ba[8]}}, ba};
    else           e_pc = e_pc + 15'd1;
    if (we) e_pg = wd;
    @(negedge clk);
    t = tag_of(r);
    if ($countones(r) > 1) t = {t, "/R8"};
    if (we && r != 0) t = {t, "/R9"};
    check(t, pc, e_pc);
    check("R10", {7'd0, pc_lo}, {7'd0, e_pc[7:0]});
  endtask

  task automatic set_page(logic [6:0] v);
    step(5'd0, '0, '0, '0, '0, 1'b1, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ld_req = 5'h1f; pg_we = 1'b1; pg_wdata = 7'h7f; alu_res = 8'hff;
    repeat (3) @(negedge clk);
    check("R1", pc, 15'd0);
    ld_req = '0; pg_we = 1'b0;
    rst_n = 1'b1;
    // R1: page latch zero after reset, seen through a low-byte write
    step(5'b00001, '0, '0, '0, 8'h5a, 1'b0, '0);
    check("R1", {8'd0, pc[14:8]}, 15'd0);
    // R2 wrap at top of space
    set_page(7'h7f);
    step(5'b00010, 11'h7fe, '0, '0, '0, 1'b0, '0);
    for (int i = 0; i < 4; i++) step('0, '0, '0, '0, '0, 1'b0, '0);
    // R3 sweep of ALU byte with several pages
    for (int p = 0; p < 8; p++) begin
      set_page(7'(p * 17));
      for (int a = 0; a < 256; a += 7) step(5'b00001, '0, '0, '0, 8'(a), 1'b0, '0);
    end
    // R4 sweep of operand with pages that differ only in low bits
    for (int p = 0; p < 128; p += 5) begin
      set_page(7'(p));
      for (int o = 0; o < 2048; o += 97) step(5'b00010, 11'(o), '0, '0, '0, 1'b0, '0);
    end
    // R5 sweep
    set_page(7'h2b);
    for (int w = 0; w < 256; w++) step(5'b00100, '0, '0, 8'(w), '0, 1'b0, '0);
    // R6 full W sweep, crossing 256-word and page boundaries
    set_page(7'h7f);
    step(5'b00001, '0, '0, '0, 8'h80, 1'b0, '0);
    for (int w = 0; w < 256; w++) step(5'b01000, '0, '0, 8'(w), '0, 1'b0, '0);
    // R7 full offset sweep, forward and backward, wrapping at both ends
    step(5'b00010, 11'h7f0, '0, '0, '0, 1'b0, '0);
    for (int b = 0; b < 512; b++) step(5'b10000, '0, 9'(b), '0, '0, 1'b0, '0);
    set_page(7'h00);
    step(5'b00001, '0, '0, '0, 8'h10, 1'b0, '0);
    for (int b = 511; b >= 256; b--) step(5'b10000, '0, 9'(b), '0, '0, 1'b0, '0);
    // R8 every request combination
    set_page(7'h55);
    for (int r = 0; r < 32; r++)
      step(5'(r), 11'h3c5, 9'h1a3, 8'h9e, 8'h61, 1'b0, '0);
    // R9 page write in the same cycle as each load, plus random mix
    for (int r = 0; r < 32; r++)
      step(5'(r), 11'(r * 61), 9'(r * 29), 8'(r * 13), 8'(r * 7), 1'b1, 7'(r * 11 + 3));
    for (int i = 0; i < 1500; i++)
      step(5'($urandom), 11'($urandom), 9'($urandom), 8'($urandom),
           8'($urandom), 1'($urandom), 7'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule